// File: doc/BRIEF.md
# Custom Instruction Coprocessor Bridge

This block sits between the decode stage of a RISC-V core and a reconfigurable accelerator fabric. When the decode stage presents an instruction whose major opcode lies in the custom-0 window, the bridge claims it. It latches both source register values and the instruction's selector fields and hands them to the fabric. It then holds the core's pipeline until a result arrives. The result goes to the destination register, to an accumulator inside the bridge, or to both. Every other opcode is left to the core.

Each instruction picks its own completion rule. In handshake mode the bridge waits for the fabric's result-valid strobe. A guard counter ends an operation the fabric never answers, returns zero and sets a sticky status bit. In delay mode the bridge takes the fabric output after a programmed number of cycles. One bridge is instantiated per core, and every core gets its own connection to the shared fabric.

Top module: `cxb_bridge`

## Requirements
- R1: An instruction is claimed (claim high) only when instr_valid is high, the bridge is idle and instr[6:0] equals 7'b0001011. Any other opcode gives claim, stall and illegal low, and op_valid stays low in the next cycle.
- R2: A claimed legal instruction starts an operation in the next cycle. op_valid is high with op_a = rs1_val, op_b = rs2_val and op_sel = {instr[31:25], instr[14:12]}. These stay unchanged until completion, and instructions presented while busy are ignored.
- R3: funct3 (instr[14:12]) selects the return path. 0 writes only the register port (rd_we pulses with rd_data in the completion cycle). 1 writes only the accumulator (acc_out takes the result after the completion edge). 2 writes both.
- R4: A custom-0 instruction with funct3 = 3 raises illegal in that cycle, with claim high. It starts no operation and leaves stall low.
- R5: With instr[25] = 1 (handshake), the operation completes in the busy cycle in which res_valid is high, and the result is res_data.
- R6: With instr[25] = 0 (delay), the operation completes in busy cycle N. The first cycle after issue is busy cycle 1. N is the delay register value at issue, and a value of 0 acts as 1. The result is res_data in that cycle.
- R7: stall is high in the issue cycle and in every busy cycle before completion. It is low in the completion cycle, and op_valid drops after that cycle.
- R8: A handshake operation without res_valid by busy cycle 255 completes in that cycle with result zero and sets timeout_flag, which stays set. If res_valid is high in cycle 255, the fabric result wins and timeout_flag is not set.
- R9: Synchronous active-high reset clears the accumulator and timeout_flag, deasserts stall and op_valid, and sets the delay register to 1. cfg_we loads cfg_delay into the delay register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Decode stage presents an instruction |
| instr | input | 32 | Instruction word |
| rs1_val | input | 32 | First source register value |
| rs2_val | input | 32 | Second source register value |
| cfg_we | input | 1 | Load strobe for the delay register |
| cfg_delay | input | 4 | New delay count |
| claim | output | 1 | Instruction belongs to the bridge |
| illegal | output | 1 | Reserved result path requested |
| stall | output | 1 | Hold the core pipeline |
| op_valid | output | 1 | Operation presented to the fabric |
| op_a | output | 32 | First operand to fabric |
| op_b | output | 32 | Second operand to fabric |
| op_sel | output | 10 | {funct7, funct3} selector to fabric |
| res_valid | input | 1 | Fabric result strobe (handshake mode) |
| res_data | input | 32 | Fabric result |
| rd_we | output | 1 | Destination register write strobe |
| rd_data | output | 32 | Destination register write value |
| acc_out | output | 32 | Accumulator contents |
| timeout_flag | output | 1 | Sticky handshake timeout status |

## Verification
The fabric's answer and the guard counter's expiry can fall in the same cycle. The bench provokes this by raising res_valid in exactly the 255th busy cycle of a handshake operation. It expects the fabric value on rd_data and the accumulator, with timeout_flag still clear. A second operation that never gets an answer must then finish in that same cycle with zero and set the flag. Delay and handshake operations are swept over every delay setting, over several latencies and over all return paths. Expected results come from the bench's own fabric arithmetic.

// File: rtl/cxb_pkg.sv
package cxb_pkg;
   localparam logic [6:0] OPC_CUSTOM0 = 7'b0001011;

   typedef enum logic [1:0] {
      PATH_RD   = 2'd0,
      PATH_ACC  = 2'd1,
      PATH_BOTH = 2'd2,
      PATH_RSV  = 2'd3
   } path_e;

   typedef struct packed {
      logic [6:0] f7;
      logic [2:0] f3;
   } sel_t;
endpackage

// File: rtl/cxb_decode.sv
module cxb_decode
   import cxb_pkg::*;
(
   input  logic       instr_valid,
   input  logic       busy,
   input  logic [6:0] opcode,
   input  logic [2:0] funct3,
   input  logic [6:0] funct7,
   output logic       claim,
   output logic       illegal,
   output logic       issue,
   output logic       mode_hs,
   output path_e      path,
   output sel_t       sel
);
   logic hit;

   always_comb begin
      hit     = instr_valid && !busy && (opcode == OPC_CUSTOM0);
      claim   = hit;
      illegal = hit && (funct3[1:0] == 2'd3);
      issue   = hit && (funct3[1:0] != 2'd3);
      mode_hs = funct7[0];
      path    = path_e'(funct3[1:0]);
      sel     = '{f7: funct7, f3: funct3};
   end

   logic unused_f3;
   assign unused_f3 = funct3[2];
endmodule

// File: rtl/cxb_timer.sv
module cxb_timer #(
   parameter int DLY_W = 4,
   parameter int TMO   = 255
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             issue,
   input  logic             busy,
   input  logic             mode_hs,
   input  logic             res_valid,
   input  logic             cfg_we,
   input  logic [DLY_W-1:0] cfg_delay,
   output logic             done,
   output logic             timed_out
);
   localparam int TW    = $clog2(TMO + 1);
   localparam int CNT_W = (TW > DLY_W) ? TW : DLY_W;

   logic [DLY_W-1:0] cfg_q, n_q;
   logic [CNT_W-1:0] cnt_q;
   logic             at_n, at_tmo;

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg_q <= DLY_W'(1);
         n_q   <= DLY_W'(1);
         cnt_q <= '0;
      end else begin
         if (cfg_we)
            cfg_q <= cfg_delay;
         if (issue) begin
            n_q   <= (cfg_q == '0) ? DLY_W'(1) : cfg_q;
            cnt_q <= CNT_W'(1);
         end else if (busy && !done) begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
      end
   end

   always_comb begin
      at_n      = (cnt_q == CNT_W'(n_q));
      at_tmo    = (cnt_q == CNT_W'(TMO));
      done      = busy && (mode_hs ? (res_valid || at_tmo) : at_n);
      timed_out = busy && mode_hs && !res_valid && at_tmo;
   end
endmodule

// File: rtl/cxb_wb.sv
module cxb_wb
   import cxb_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            done,
   input  logic            timed_out,
   input  path_e           path,
   input  logic [XLEN-1:0] res_data,
   output logic            rd_we,
   output logic [XLEN-1:0] rd_data,
   output logic [XLEN-1:0] acc_q
);
   logic [XLEN-1:0] result;

   always_comb begin
      result  = timed_out ? '0 : res_data;
      rd_we   = done && (path != PATH_ACC);
      rd_data = result;
   end

   always_ff @(posedge clk) begin
      if (rst)
         acc_q <= '0;
      else if (done && (path != PATH_RD))
         acc_q <= result;
   end
endmodule

// File: rtl/cxb_bridge.sv
module cxb_bridge
   import cxb_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int DLY_W = 4,
   parameter int TMO   = 255
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             instr_valid,
   input  logic [31:0]      instr,
   input  logic [XLEN-1:0]  rs1_val,
   input  logic [XLEN-1:0]  rs2_val,
   input  logic             cfg_we,
   input  logic [DLY_W-1:0] cfg_delay,
   output logic             claim,
   output logic             illegal,
   output logic             stall,
   output logic             op_valid,
   output logic [XLEN-1:0]  op_a,
   output logic [XLEN-1:0]  op_b,
   output logic [9:0]       op_sel,
   input  logic             res_valid,
   input  logic [XLEN-1:0]  res_data,
   output logic             rd_we,
   output logic [XLEN-1:0]  rd_data,
   output logic [XLEN-1:0]  acc_out,
   output logic             timeout_flag
);
   if (XLEN < 8 || DLY_W < 1 || TMO < 2) begin : g_param_err
      $error("cxb_bridge: XLEN>=8, DLY_W>=1, TMO>=2 required");
   end

   logic  busy_q, hs_q, sticky_q;
   logic  issue, mode_hs, done, timed_out;
   path_e path_d, path_q;
   sel_t  sel_d, sel_q;
   logic [XLEN-1:0] a_q, b_q;

   cxb_decode i_dec (
      .instr_valid (instr_valid),
      .busy        (busy_q),
      .opcode      (instr[6:0]),
      .funct3      (instr[14:12]),
      .funct7      (instr[31:25]),
      .claim       (claim),
      .illegal     (illegal),
      .issue       (issue),
      .mode_hs     (mode_hs),
      .path        (path_d),
      .sel         (sel_d)
   );

   cxb_timer #(.DLY_W(DLY_W), .TMO(TMO)) i_tmr (
      .clk       (clk),
      .rst       (rst),
      .issue     (issue),
      .busy      (busy_q),
      .mode_hs   (hs_q),
      .res_valid (res_valid),
      .cfg_we    (cfg_we),
      .cfg_delay (cfg_delay),
      .done      (done),
      .timed_out (timed_out)
   );

   cxb_wb #(.XLEN(XLEN)) i_wb (
      .clk       (clk),
      .rst       (rst),
      .done      (done),
      .timed_out (timed_out),
      .path      (path_q),
      .res_data  (res_data),
      .rd_we     (rd_we),
      .rd_data   (rd_data),
      .acc_q     (acc_out)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q   <= 1'b0;
         hs_q     <= 1'b0;
         sticky_q <= 1'b0;
         path_q   <= PATH_RD;
         sel_q    <= '0;
         a_q      <= '0;
         b_q      <= '0;
      end else begin
         if (issue) begin
            busy_q <= 1'b1;
            hs_q   <= mode_hs;
            path_q <= path_d;
            sel_q  <= sel_d;
            a_q    <= rs1_val;
            b_q    <= rs2_val;
         end else if (done) begin
            busy_q <= 1'b0;
         end
         if (timed_out)
            sticky_q <= 1'b1;
      end
   end

   always_comb begin
      stall        = issue || (busy_q && !done);
      op_valid     = busy_q;
      op_a         = a_q;
      op_b         = b_q;
      op_sel       = sel_q;
      timeout_flag = sticky_q;
   end

   logic unused_fields;
   assign unused_fields = ^{instr[24:15], instr[11:7]};
endmodule

// File: rtl/cxb_bridge_chk.sv
module cxb_bridge_chk #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst,
   input logic            instr_valid,
   input logic [6:0]      opc,
   input logic            claim,
   input logic            illegal,
   input logic            stall,
   input logic            op_valid,
   input logic [XLEN-1:0] op_a,
   input logic [XLEN-1:0] op_b,
   input logic [9:0]      op_sel,
   input logic            res_valid,
   input logic [XLEN-1:0] acc_out,
   input logic            timeout_flag
);
   a_r1_foreign_opcode: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && !op_valid && opc != 7'b0001011) |-> (!claim && !stall))
      else $error("R1 foreign opcode claimed");

   a_r1_no_issue: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && !op_valid && opc != 7'b0001011) |=> !op_valid)
      else $error("R1 foreign opcode issued");

   a_r2_hold: assert property (@(posedge clk) disable iff (rst)
      (op_valid && stall) |=> (op_valid && $stable(op_a) && $stable(op_b) && $stable(op_sel)))
      else $error("R2 operands moved");

   a_r3_acc_quiet: assert property (@(posedge clk) disable iff (rst)
      !op_valid |=> $stable(acc_out))
      else $error("R3 accumulator moved while idle");

   a_r4_illegal: assert property (@(posedge clk) disable iff (rst)
      illegal |-> (claim && !stall))
      else $error("R4 illegal stalls");

   a_r4_no_issue: assert property (@(posedge clk) disable iff (rst)
      illegal |=> !op_valid)
      else $error("R4 illegal issued");

   a_r5_hs_done: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_sel[3] && res_valid) |-> !stall)
      else $error("R5 handshake not completed");

   a_r7_release: assert property (@(posedge clk) disable iff (rst)
      (op_valid && !stall) |=> !op_valid)
      else $error("R7 busy after release");

   a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
      timeout_flag |=> timeout_flag)
      else $error("R8 sticky flag cleared");
endmodule

bind cxb_bridge cxb_bridge_chk #(.XLEN(XLEN)) i_chk (
   .clk          (clk),
   .rst          (rst),
   .instr_valid  (instr_valid),
   .opc          (instr[6:0]),
   .claim        (claim),
   .illegal      (illegal),
   .stall        (stall),
   .op_valid     (op_valid),
   .op_a         (op_a),
   .op_b         (op_b),
   .op_sel       (op_sel),
   .res_valid    (res_valid),
   .acc_out      (acc_out),
   .timeout_flag (timeout_flag)
);

// File: tb/test_cxb_bridge.sv
module test_cxb_bridge;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        instr_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] rs1_val = '0, rs2_val = '0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_delay = '0;
   logic        claim, illegal, stall, op_valid, rd_we, timeout_flag;
   logic [31:0] op_a, op_b, rd_data, acc_out, res_data;
   logic [9:0]  op_sel;
   logic        res_valid = 1'b0;

   int errors = 0;
   int checks = 0;
   int cur_n = 1;
   logic [31:0] exp_acc = '0;
   bit finished = 0;

   always #10 clk = ~clk;

   cxb_bridge i_cxb_bridge (
      .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr),
      .rs1_val(rs1_val), .rs2_val(rs2_val), .cfg_we(cfg_we), .cfg_delay(cfg_delay),
      .claim(claim), .illegal(illegal), .stall(stall), .op_valid(op_valid),
      .op_a(op_a), .op_b(op_b), .op_sel(op_sel), .res_valid(res_valid),
      .res_data(res_data), .rd_we(rd_we), .rd_data(rd_data), .acc_out(acc_out),
      .timeout_flag(timeout_flag)
   );

   function automatic logic [31:0] fab(input logic [31:0] a, input logic [31:0] b,
                                       input logic [9:0] s);
      return (a ^ {b[15:0], b[31:16]}) + {22'd0, s};
   endfunction

   assign res_data = fab(op_a, op_b, op_sel);

   function automatic logic [31:0] mk(input logic [6:0] f7, input logic [2:0] f3,
                                      input logic [6:0] opc);
      return {f7, 5'd2, 5'd1, f3, 5'd3, opc};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   task automatic set_cfg(input logic [3:0] v);
      cfg_we = 1'b1; cfg_delay = v;
      @(negedge clk);
      cfg_we = 1'b0;
      cur_n = (v == 0) ? 1 : int'(v);
   endtask

   // Runs one legal operation. hs: handshake; lat: busy cycle of res_valid (0 = never).
   task automatic run_op(input bit hs, input logic [1:0] path, input logic [31:0] a,
                         input logic [31:0] b, input int lat, input bit poke);
      logic [6:0]  f7 = {6'b010110, hs};
      logic [2:0]  f3 = {1'b0, path};
      logic [31:0] exp_r;
      int          done_k;
      bit          tmo;
      tmo    = hs && (lat == 0);
      done_k = hs ? (tmo ? 255 : lat) : cur_n;
      exp_r  = tmo ? 32'd0 : fab(a, b, {f7, f3});
      instr = mk(f7, f3, 7'b0001011); rs1_val = a; rs2_val = b; instr_valid = 1'b1;
      #1;
      chk(claim && stall && !illegal, "R7 issue-cycle stall", {29'd0, claim, stall, illegal}, 32'h6);
      @(negedge clk);
      instr_valid = 1'b0; rs1_val = ~a; rs2_val = ~b;
      for (int k = 1; k <= 300; k++) begin
         if (hs && k == lat) res_valid = 1'b1;
         if (poke && k == 2) begin
            instr = mk(7'h01, 3'd0, 7'b0001011); instr_valid = 1'b1;
         end
         #1;
         chk(op_valid && op_a == a && op_b == b && op_sel == {f7, f3},
             "R2 operands held", op_a, a);
         if (poke && k == 2)
            chk(!claim, "R2 busy ignores new instr", {31'd0, claim}, 32'd0);
         if (k == done_k) begin
            chk(!stall, "R7 release at completion", {31'd0, stall}, 32'd0);
            chk(rd_we == (path != 2'd1), "R3 rd_we by path", {31'd0, rd_we},
                {31'd0, path != 2'd1});
            if (path != 2'd1)
               chk(rd_data == exp_r, hs ? (tmo ? "R8 timeout zero" : "R5 handshake result")
                   : "R6 delay result", rd_data, exp_r);
            @(negedge clk);
            res_valid = 1'b0; instr_valid = 1'b0;
            if (path != 2'd0) exp_acc = exp_r;
            #1;
            chk(acc_out == exp_acc, "R3 accumulator", acc_out, exp_acc);
            chk(!op_valid && !stall, "R7 idle after done", {30'd0, op_valid, stall}, 32'd0);
            break;
         end
         chk(stall && !rd_we, "R7 stall while busy", {30'd0, stall, rd_we}, 32'h2);
         @(negedge clk);
         instr_valid = 1'b0;
      end
   endtask

   initial begin
      for (int c = 0; c < 150000; c++) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      summary();
   end

   initial begin
      logic [31:0] pats [4];
      logic [6:0]  others [5];
      pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
      pats[2] = 32'h1234_5678; pats[3] = 32'h8000_0001;
      others[0] = 7'b0110011; others[1] = 7'b0101011; others[2] = 7'b1011011;
      others[3] = 7'b0001010; others[4] = 7'b0001111;

      @(negedge clk); @(negedge clk);
      rst = 1'b0;
      #1;
      // R9 reset state
      chk(!stall && !op_valid && acc_out == 0 && !timeout_flag, "R9 reset state",
          {acc_out[27:0], stall, op_valid, timeout_flag, 1'b0}, 32'd0);
      @(negedge clk);

      // R6 / R9: reset delay value is 1
      run_op(1'b0, 2'd0, 32'hA5A5_0001, 32'h0F0F_3333, 0, 1'b0);

      // R1 foreign opcodes
      foreach (others[i]) begin
         instr = mk(7'h01, 3'd0, others[i]); instr_valid = 1'b1;
         #1;
         chk(!claim && !stall && !illegal, "R1 foreign opcode", {29'd0, claim, stall, illegal}, 32'd0);
         @(negedge clk);
         instr_valid = 1'b0;
         #1;
         chk(!op_valid, "R1 no issue", {31'd0, op_valid}, 32'd0);
         @(negedge clk);
      end

      // R4 reserved path, both modes
      for (int m = 0; m < 2; m++) begin
         instr = mk({6'd0, m[0]}, 3'd3, 7'b0001011); instr_valid = 1'b1;
         #1;
         chk(illegal && claim && !stall, "R4 illegal flag", {29'd0, illegal, claim, stall}, 32'h6);
         @(negedge clk);
         instr_valid = 1'b0;
         #1;
         chk(!op_valid && !rd_we && acc_out == exp_acc, "R4 no operation",
             {30'd0, op_valid, rd_we}, 32'd0);
         @(negedge clk);
      end

      // R6 delay sweep over every setting and path
      for (int n = 0; n < 16; n++) begin
         set_cfg(n[3:0]);
         for (int p = 0; p < 3; p++)
            run_op(1'b0, p[1:0], pats[(n + p) % 4] ^ n, pats[(n + 2 * p + 1) % 4] + p, 0, 1'b0);
      end

      // R6: delay latched at issue, write during flight affects next op only
      set_cfg(4'd3);
      fork
         run_op(1'b0, 2'd2, 32'hDEAD_0003, 32'h0000_BEEF, 0, 1'b0);
         begin @(negedge clk); cfg_we = 1'b1; cfg_delay = 4'd7; @(negedge clk); cfg_we = 1'b0; end
      join
      cur_n = 7;
      run_op(1'b0, 2'd0, 32'h0707_0707, 32'h7, 0, 1'b0);

      // R5 handshake sweep with ignored instructions while busy (R2)
      for (int lat = 1; lat <= 6; lat++)
         for (int p = 0; p < 3; p++)
            run_op(1'b1, p[1:0], pats[(lat + p) % 4] + lat, pats[p] ^ (lat << 8), lat, lat >= 3);

      // R8 collision: answer in the last guard cycle wins
      run_op(1'b1, 2'd2, 32'h1357_9BDF, 32'h2468_ACE0, 255, 1'b0);
      #1;
      chk(!timeout_flag, "R8 collision no timeout", {31'd0, timeout_flag}, 32'd0);
      // R8 genuine timeout
      run_op(1'b1, 2'd2, 32'h1111_2222, 32'h3333_4444, 0, 1'b0);
      chk(timeout_flag, "R8 timeout sticky set", {31'd0, timeout_flag}, 32'd1);
      @(negedge clk);
      run_op(1'b1, 2'd0, 32'h5, 32'h6, 2, 1'b0);
      chk(timeout_flag, "R8 flag stays", {31'd0, timeout_flag}, 32'd1);

      // R9 reset clears state and delay register
      set_cfg(4'd9);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      #1;
      chk(!timeout_flag && acc_out == 0 && !stall, "R9 reset clears",
          {acc_out[29:0], timeout_flag, stall}, 32'd0);
      exp_acc = '0; cur_n = 1;
      @(negedge clk);
      run_op(1'b0, 2'd1, 32'hCAFE_F00D, 32'h0000_0001, 0, 1'b0);

      summary();
   end
endmodule